// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a 64-word by 8-bit first-in first-out buffer that joins two unrelated clock domains. Each rising edge of the load clock stores the input word unless the buffer is full. Each rising edge of the unload clock discards the head word unless the buffer is empty. There are no separate load or unload enables: the producer and the consumer control the flow by gating their own clocks.

The oldest stored word falls through to the data outputs as soon as the reading side sees it, with no unload request needed. An unload edge moves the output to the next word. Two active-low flags report full and empty. The data outputs go high-impedance when the output enable is low, so several buffers can share a bus side by side to build wider words.

Each pointer crosses into the other domain as a Gray-coded value through two flip-flops. For that reason each flag asserts on the edge that causes its condition, but it clears a couple of edges of its own clock late.

Top module: `dcft_fifo`

## Requirements
- R1: Words leave the buffer in the order they were stored, unchanged, and up to 64 words can be held at once.
- R2: A load-clock edge with `full_n` high before the edge stores `ld_data`. An unload-clock edge with `empty_n` high before the edge removes the head word. The pointers move by at most one step, in Gray code, per edge.
- R3: While full, load-clock edges leave the stored words unchanged, and the number of held words never exceeds 64.
- R4: While empty, unload-clock edges have no effect: a word loaded afterwards is the next word presented.
- R5: `full_n` goes low right after the load edge that stores the 64th word. After an unload frees space, `full_n` is high again within two load-clock edges.
- R6: `empty_n` goes low right after the unload edge that removes the last word. After a load into an empty buffer, `empty_n` is high within two unload-clock edges.
- R7: `rst_n` low clears both pointers asynchronously, drives `empty_n` low and `full_n` high, and drops loads. After `rst_n` rises, the first two edges of each clock are ignored.
- R8: While `empty_n` is high, `q` shows the head word without any unload edge, including the first word loaded after a reset or after draining.
- R9: With `oe` low, `q` is high-impedance. `oe` never changes `full_n` or `empty_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ld_clk | input | 1 | Load clock; each rising edge stores a word |
| ld_data | input | 8 | Word to store |
| full_n | output | 1 | Low when full (load domain) |
| ul_clk | input | 1 | Unload clock; each rising edge removes the head word |
| oe | input | 1 | Output enable; low puts `q` in high-impedance |
| q | output | 8 | Head word, tri-state |
| empty_n | output | 1 | Low when empty (unload domain) |

## Verification
A wrong pointer or a stale synchronizer shows at the ports in one of two ways. Either `q` presents a word out of order on the next unload edge, or a flag stays open over an empty or full buffer one edge after the limit is reached. A pointer that skips a value loses or repeats a word, and a reference queue catches this the first time the bad slot reaches the head. A flag that never clears stalls progress, and this is caught by explicit checks two edges after the other side moves.

// File: rtl/dcft_fifo.sv
module dcft_fifo #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          rst_n,
  input  logic          ld_clk,
  input  logic [DW-1:0] ld_data,
  output logic          full_n,
  input  logic          ul_clk,
  input  logic          oe,
  output wire  [DW-1:0] q,
  output logic          empty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [1:0]    ld_rs, ul_rs;
  logic          ld_rst_n, ul_rst_n;
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic [PW-1:0] rbin, rgray, wq1, wq2;
  logic [DW-1:0] mem [DEPTH];
  logic          full, empty;

  assign ld_rst_n = ld_rs[1];
  assign ul_rst_n = ul_rs[1];

  always_ff @(posedge ld_clk or negedge rst_n)
    if (!rst_n) ld_rs <= '0;
    else        ld_rs <= {ld_rs[0], 1'b1};

  always_ff @(posedge ul_clk or negedge rst_n)
    if (!rst_n) ul_rs <= '0;
    else        ul_rs <= {ul_rs[0], 1'b1};

  wire [PW-1:0] wbin_nx = wbin + 1'b1;
  wire [PW-1:0] rbin_nx = rbin + 1'b1;

  assign full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign empty = (rgray == wq2);
  assign full_n  = ~full;
  assign empty_n = ~empty;

  always_ff @(posedge ld_clk or negedge ld_rst_n)
    if (!ld_rst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (!full) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge ld_clk)
    if (ld_rst_n && !full) mem[wbin[AW-1:0]] <= ld_data;

  always_ff @(posedge ul_clk or negedge ul_rst_n)
    if (!ul_rst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (!empty) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end

  assign q = oe ? mem[rbin[AW-1:0]] : {DW{1'bz}};

  a_r3_depth_bound: assert property (@(posedge ld_clk) disable iff (!ld_rst_n)
    (wbin - rbin) <= PW'(DEPTH));

  a_r5_full_at_depth: assert property (@(posedge ld_clk) disable iff (!ld_rst_n)
    ((wbin - rbin) == PW'(DEPTH)) |-> !full_n);

  a_r6_empty_at_zero: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    (wbin == rbin) |-> !empty_n);

  a_r2_gray_step: assert property (@(posedge ld_clk) disable iff (!ld_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r2_rd_gray_step: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/test_dcft_fifo.sv
`timescale 1ns/1ps
module test_dcft_fifo;
  logic       clk = 0;
  logic       rst_n = 0, ld_clk = 0, ul_clk = 0, oe = 1;
  logic [7:0] ld_data = 0;
  logic       full_n, empty_n;
  wire  [7:0] q_w;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] mq[$];

  for (genvar b = 0; b < 8; b++) begin : g_pu
    pullup (q_w[b]);
  end

  dcft_fifo i_dcft_fifo (.rst_n(rst_n), .ld_clk(ld_clk), .ld_data(ld_data), .full_n(full_n),
    .ul_clk(ul_clk), .oe(oe), .q(q_w), .empty_n(empty_n));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic raw_ld();
    #2 ld_clk = 1; #3 ld_clk = 0; #2;
  endtask

  task automatic raw_ul();
    #3 ul_clk = 1; #4 ul_clk = 0; #4;
  endtask

  task automatic ld_edge(input logic [7:0] d);
    logic wr;
    ld_data = d;
    #2 wr = full_n;
    ld_clk = 1;
    if (wr) mq.push_back(d);
    #3 ld_clk = 0; #2;
  endtask

  task automatic ul_edge();
    logic rd;
    #3 rd = empty_n;
    if (rd) begin
      chk(mq.size() > 0, "R4 empty_n high with nothing stored", mq.size(), 1);
      if (mq.size() > 0) begin
        chk(q_w == mq[0], "R1 head word order", q_w, mq[0]);
        void'(mq.pop_front());
      end
    end
    ul_clk = 1; #4 ul_clk = 0; #4;
  endtask

  task automatic safety();
    if (mq.size() == 64) chk(full_n == 0, "R5 full_n low at 64 words", full_n, 0);
    if (mq.size() == 0)  chk(empty_n == 0, "R6 empty_n low at zero words", empty_n, 0);
    if (empty_n && mq.size() > 0) chk(q_w == mq[0], "R8 head word visible", q_w, mq[0]);
    if (full_n) chk(mq.size() < 64, "R3 room while full_n high", mq.size(), 63);
  endtask

  initial begin
    #20;
    chk(empty_n == 0, "R7 empty_n in reset", empty_n, 0);
    chk(full_n == 1, "R7 full_n in reset", full_n, 1);
    ld_data = 8'h11;
    raw_ld(); raw_ld(); raw_ld();
    rst_n = 1;
    raw_ld(); raw_ld(); raw_ul(); raw_ul(); raw_ul(); raw_ul();
    chk(empty_n == 0, "R7 loads during reset dropped", empty_n, 0);

    ld_edge(8'h3C);
    ul_edge(); ul_edge();
    chk(mq.size() == 1, "R6 no unload before flag rises", mq.size(), 1);
    chk(empty_n == 1, "R6 empty_n high within two unload edges", empty_n, 1);
    chk(q_w == 8'h3C, "R8 first word falls through", q_w, 8'h3C);
    oe = 0; #1;
    chk(q_w == 8'hFF, "R9 q high-impedance with oe low", q_w, 8'hFF);
    chk(empty_n == 1 && full_n == 1, "R9 flags unaffected by oe", {empty_n, full_n}, 3);
    oe = 1; #1;
    ul_edge();
    chk(empty_n == 0, "R6 empty_n low after last unload", empty_n, 0);
    ul_edge(); ul_edge(); ul_edge();
    ld_edge(8'h5A);
    ul_edge(); ul_edge();
    chk(q_w == 8'h5A, "R4 unloads while empty ignored", q_w, 8'h5A);
    ul_edge();

    for (int i = 0; i < 70; i++) begin
      ld_edge(8'(i + 1));
      if (i == 63) chk(full_n == 0, "R5 full_n low after 64th load", full_n, 0);
    end
    chk(mq.size() == 64, "R3 excess loads ignored", mq.size(), 64);
    ul_edge(); ul_edge();
    chk(mq.size() == 64 && empty_n == 1, "R6 empty_n rises after two unload edges", mq.size(), 64);
    ul_edge();
    ld_edge(8'hAA); ld_edge(8'hAA);
    chk(full_n == 1, "R5 full_n high within two load edges", full_n, 1);
    for (int k = 0; k < 200 && mq.size() > 0; k++) ul_edge();
    chk(mq.size() == 0, "R1 drained all words in order", mq.size(), 0);
    safety();

    for (int s = 0; s < 4000; s++) begin
      int thr;
      thr = ((s / 500) % 2 == 0) ? 70 : 30;
      if (int'($urandom_range(99)) < thr) ld_edge(8'($urandom_range(254)));
      else ul_edge();
      safety();
    end
    for (int k = 0; k < 200 && mq.size() > 0; k++) ul_edge();
    chk(mq.size() == 0, "R2 final drain", mq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule